// File: doc/BRIEF.md
# Composite Sync Separator with Output Stage

This block turns a horizontal (or composite) sync input and a vertical sync input into a pair of sync outputs for a display controller. Both raw inputs are active-low and asynchronous; each passes through a two-flop synchroniser before any measurement is made. A mode input selects between separate sync, where each output follows its own input, and composite sync, where only the horizontal/composite line is used.

In composite mode the block measures each low-going pulse on the composite line in clock cycles. Short pulses such as line sync, serrations and equalising pulses go out as horizontal sync. A pulse that stays low for the programmed threshold or longer starts extracted vertical sync. Extracted vertical sync ends on the trailing edge of the first short pulse that follows. The threshold is a port in clock cycles. At the intended 2 MHz clock, the default of 18 cycles rounds up the 8.75 us maximum.

Each output has its own polarity control. A single enable drives both outputs to their inactive levels when it is low. In composite mode only, an inhibit bit suppresses horizontal sync while extracted vertical sync is active.

Top module: `sync_separator_top`

## Requirements
- R1: While `rst_n` is low, `hs_out` and `vs_out` are both 0, and extraction state is cleared.
- R2: In separate mode with `out_en`=1 and `hs_pol`=2'b01, `hs_out` is the inverse of `hs_in` delayed by exactly three clock edges (two synchroniser stages plus one output register).
- R3: In separate mode with `out_en`=1 and `vs_pol`=1, `vs_out` is the inverse of `vs_in` delayed by exactly three clock edges.
- R4: In composite mode, once the synchronised composite line has been low for `max(thresh,1)` consecutive cycles, extracted vertical sync becomes active at the next edge. `vs_out` shows it one edge after that.
- R5: In composite mode, a composite pulse shorter than `max(thresh,1)` cycles never starts extracted vertical sync. This holds for a width of exactly `thresh`-1.
- R6: Extracted vertical sync ends one edge after the synchronised trailing edge of the first pulse narrower than the threshold. The trailing edge of a long pulse does not end it.
- R7: In composite mode with `hs_inhibit`=1, `hs_out` shows no active level while extracted vertical sync is active.
- R8: In separate mode, `hs_inhibit` has no effect on `hs_out`.
- R9: With `out_en`=0, at the next edge `hs_out` = NOT `hs_pol[0]` and `vs_out` = NOT `vs_pol`.
- R10: `hs_pol` encoding: 2'b00 gives an active-low pulse and 2'b01 an active-high pulse. 2'b10 holds the output at 0 and 2'b11 holds it at 1 while enabled.
- R11: `vs_pol`=1 gives an active-high vertical output and `vs_pol`=0 an active-low one.
- R12: A `thresh` value of 0 is treated as 1, so in composite mode any pulse of one synchronised cycle starts vertical sync.
- R13: In separate mode the extraction state stays cleared, so `vs_out` follows only `vs_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Horizontal or composite sync, active low, asynchronous |
| vs_in | input | 1 | Vertical sync, active low, asynchronous (separate mode) |
| comp_mode | input | 1 | 1 = composite extraction, 0 = separate sync |
| thresh | input | CNT_W (8) | Extraction threshold in clock cycles |
| out_en | input | 1 | Shared output enable |
| hs_pol | input | 2 | Horizontal output polarity/hold field |
| vs_pol | input | 1 | Vertical output polarity, 1 = active high |
| hs_inhibit | input | 1 | Suppress horizontal output during extracted vertical sync (composite only) |
| hs_out | output | 1 | Horizontal sync output |
| vs_out | output | 1 | Vertical sync output |

## Verification
The bench targets pulses of exactly `thresh`-1 and `thresh` cycles. A comparison off by one there would start vertical sync a pulse early or miss it. It also checks that vertical sync outlasts the trailing edge of the long pulses and ends only after the first short pulse; a design that cleared on any trailing edge would make single-pulse vertical bursts. The inhibit bit is toggled in separate mode to catch blanking that ignores the mode. A zero threshold and all four horizontal polarity codes, with the enable both on and off, are exercised against a cycle model kept in the bench.

// File: rtl/sync_sep_pkg.sv
package sync_sep_pkg;

  typedef enum logic [1:0] {
    HP_ACT_LOW  = 2'b00,
    HP_ACT_HIGH = 2'b01,
    HP_HOLD_LO  = 2'b10,
    HP_HOLD_HI  = 2'b11
  } hpol_e;

  // threshold of zero is promoted to one cycle
  function automatic int eff_thresh(int t);
    return (t == 0) ? 1 : t;
  endfunction

  // map an active flag to a pin level for a given polarity (1 = active high)
  function automatic logic pin_level(logic act, logic act_high);
    return act_high ? act : !act;
  endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/comp_pulse_classifier.sv
module comp_pulse_classifier
  import sync_sep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_mode,
  input  logic             line_act,
  input  logic [CNT_W-1:0] thresh,
  output logic             vsx,
  output logic             long_ev,
  output logic             short_end_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] thr_e;

  assign thr_e = CNT_W'(eff_thresh(int'(thresh)));

  // current active cycle reaches the threshold
  assign long_ev      = line_act && (run_len >= thr_e - 1'b1);
  // line just went idle after a pulse narrower than the threshold
  assign short_end_ev = !line_act && (run_len != '0) && (run_len < thr_e);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (line_act) begin
      if (run_len != CNT_MAX) run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !comp_mode) vsx <= 1'b0;
    else if (long_ev)         vsx <= 1'b1;
    else if (short_end_ev)    vsx <= 1'b0;
  end
endmodule

// File: rtl/sync_out_stage.sv
module sync_out_stage
  import sync_sep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       comp_mode,
  input  logic       out_en,
  input  logic [1:0] hs_pol,
  input  logic       vs_pol,
  input  logic       hs_inhibit,
  input  logic       line_act,
  input  logic       vsep_act,
  input  logic       vsx,
  output logic       blank_w,
  output logic       hs_out,
  output logic       vs_out
);
  logic h_pulse, v_pulse, h_next, v_next;

  assign blank_w = comp_mode && hs_inhibit && vsx;
  assign h_pulse = line_act && !blank_w;
  assign v_pulse = comp_mode ? vsx : vsep_act;

  always_comb begin
    if (!out_en)       h_next = !hs_pol[0];
    else if (hs_pol[1]) h_next = hs_pol[0];
    else               h_next = pin_level(h_pulse, hs_pol[0]);
    v_next = out_en ? pin_level(v_pulse, vs_pol) : !vs_pol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_out <= 1'b0;
      vs_out <= 1'b0;
    end else begin
      hs_out <= h_next;
      vs_out <= v_next;
    end
  end
endmodule

// File: rtl/sync_separator_top.sv
module sync_separator_top #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             comp_mode,
  input  logic [CNT_W-1:0] thresh,
  input  logic             out_en,
  input  logic [1:0]       hs_pol,
  input  logic             vs_pol,
  input  logic             hs_inhibit,
  output logic             hs_out,
  output logic             vs_out
);
  logic [1:0] raw_s;
  logic       line_act, vsep_act;
  logic       vsx, long_ev, short_end_ev, blank_w;

  sync_2ff #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({vs_in, hs_in}), .q(raw_s)
  );

  assign line_act = !raw_s[0];
  assign vsep_act = !raw_s[1];

  comp_pulse_classifier #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .line_act(line_act),
    .thresh(thresh), .vsx(vsx), .long_ev(long_ev), .short_end_ev(short_end_ev)
  );

  sync_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .out_en(out_en),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_inhibit(hs_inhibit),
    .line_act(line_act), .vsep_act(vsep_act), .vsx(vsx),
    .blank_w(blank_w), .hs_out(hs_out), .vs_out(vs_out)
  );
endmodule

// File: rtl/sync_separator_chk.sv
module sync_separator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       comp_mode,
  input logic       out_en,
  input logic [1:0] hs_pol,
  input logic       vs_pol,
  input logic       hs_inhibit,
  input logic       line_act,
  input logic       vsx,
  input logic       long_ev,
  input logic       short_end_ev,
  input logic       hs_out,
  input logic       vs_out
);
  AST_LONG_SETS_VSX: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode && long_ev) |=> vsx); // R4

  AST_VSX_NEEDS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsx) |-> $past(long_ev)); // R5

  AST_SHORT_ENDS_VSX: assert property (@(posedge clk) disable iff (!rst_n)
    (vsx && short_end_ev && comp_mode) |=> !vsx); // R6

  AST_INHIBIT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_en && comp_mode && hs_inhibit && vsx && hs_pol == 2'b01))
      |-> !hs_out); // R7

  AST_SEP_HS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_en && !comp_mode && hs_pol == 2'b01))
      |-> (hs_out == $past(line_act))); // R8

  AST_DISABLED_VS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(out_en)) |-> (vs_out == !$past(vs_pol))); // R9

  AST_DISABLED_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(out_en)) |-> (hs_out == !$past(hs_pol[0]))); // R9

  AST_SEP_NO_VSX: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(comp_mode) |-> !vsx); // R13
endmodule

bind sync_separator_top sync_separator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .out_en(out_en),
  .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_inhibit(hs_inhibit),
  .line_act(line_act), .vsx(vsx), .long_ev(long_ev),
  .short_end_ev(short_end_ev), .hs_out(hs_out), .vs_out(vs_out)
);

// File: tb/tb_sync_separator_top.sv
module tb_sync_separator_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in = 1'b1, vs_in = 1'b1;
  logic       comp_mode = 1'b0;
  logic [7:0] thresh = 8'd18;
  logic       out_en = 1'b0;
  logic [1:0] hs_pol = 2'b01;
  logic       vs_pol = 1'b1;
  logic       hs_inhibit = 1'b0;
  logic       hs_out, vs_out;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  sync_separator_top dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .comp_mode(comp_mode), .thresh(thresh), .out_en(out_en),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_inhibit(hs_inhibit),
    .hs_out(hs_out), .vs_out(vs_out)
  );

  // ---------------- bench reference, written from the requirements
  logic h1 = 1, h2 = 1, v1 = 1, v2 = 1;
  int   width_seen = 0;
  logic vert = 0, exp_h = 0, exp_v = 0;

  function automatic int thr_of(logic [7:0] t);
    return (t == 8'd0) ? 1 : int'(t);
  endfunction

  function automatic logic hs_expect(logic en, logic [1:0] pol, logic pulse);
    if (!en)    return ~pol[0];
    if (pol[1]) return pol[0];
    return pol[0] ? pulse : ~pulse;
  endfunction

  function automatic logic vs_expect(logic en, logic pol, logic pulse);
    if (!en) return ~pol;
    return (pulse == pol);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= 1; h2 <= 1; v1 <= 1; v2 <= 1;
      width_seen <= 0; vert <= 0; exp_h <= 0; exp_v <= 0;
    end else begin
      automatic logic low_now = (h2 == 1'b0);
      automatic int   lim = thr_of(thresh);
      h1 <= hs_in; h2 <= h1; v1 <= vs_in; v2 <= v1;
      width_seen <= low_now ? ((width_seen >= 255) ? 255 : width_seen + 1) : 0;
      if (!comp_mode) vert <= 0;
      else if (low_now && (width_seen + 1 >= lim)) vert <= 1;
      else if (!low_now && width_seen > 0 && width_seen < lim) vert <= 0;
      exp_h <= hs_expect(out_en, hs_pol, low_now && !(comp_mode && hs_inhibit && vert));
      exp_v <= vs_expect(out_en, vs_pol, comp_mode ? vert : (v2 == 1'b0));
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "hs_out", hs_out, exp_h);
      chk(cur_req, "vs_out", vs_out, exp_v);
    end
  end

  // ---------------- stimulus helpers (drive at negedge)
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpulse(int w, int gap);
    hs_in = 1'b0; idle(w);
    hs_in = 1'b1; idle(gap);
  endtask

  task automatic frame(int thr, int nlong);
    cur_req = "R5";
    for (int i = 0; i < 5; i++) cpulse(2 + ($urandom % (thr - 2)), 10 + ($urandom % 8));
    cur_req = "R4";
    for (int i = 0; i < nlong; i++) cpulse(thr + ($urandom % 10), 3 + ($urandom % 4));
    cur_req = "R6";
    for (int i = 0; i < 5; i++) cpulse(2 + ($urandom % (thr - 2)), 10 + ($urandom % 8));
  endtask

  task automatic random_sep(int n);
    for (int i = 0; i < n; i++) begin
      if (($urandom % 6) == 0) hs_in = ~hs_in;
      if (($urandom % 15) == 0) vs_in = ~vs_in;
      @(negedge clk);
    end
    hs_in = 1'b1; vs_in = 1'b1; idle(4);
  endtask

  initial begin
    void'($urandom(32'h5e9a_1c07));
    // R1 reset state
    idle(3);
    chk("R1", "hs_out in reset", hs_out, 1'b0);
    chk("R1", "vs_out in reset", vs_out, 1'b0);
    rst_n = 1'b1; out_en = 1'b1; idle(4);

    // R2 / R3 separate mode latency
    cur_req = "R2";
    hs_in = 1'b0; @(negedge clk); hs_in = 1'b1;
    idle(1); chk("R2", "hs_out before 3rd edge", hs_out, 1'b0);
    idle(1); chk("R2", "hs_out after 3rd edge", hs_out, 1'b1);
    idle(4);
    cur_req = "R3";
    vs_in = 1'b0; idle(2); chk("R3", "vs_out before 3rd edge", vs_out, 1'b0);
    idle(1); chk("R3", "vs_out after 3rd edge", vs_out, 1'b1);
    vs_in = 1'b1; idle(5);
    cur_req = "R2"; random_sep(500);

    // R8 inhibit ignored in separate mode; R13 no extraction there
    hs_inhibit = 1'b1; cur_req = "R8"; random_sep(400);
    cur_req = "R13";
    cpulse(40, 10);
    chk("R13", "vs_out after long hs pulse in separate mode", vs_out, 1'b0);

    // composite extraction R4 R5 R6
    hs_inhibit = 1'b0; comp_mode = 1'b1; idle(4);
    // exact boundary: width thresh-1 must not start vertical
    cur_req = "R5"; cpulse(17, 12);
    chk("R5", "vs_out after 17-cycle pulse", vs_out, 1'b0);
    // width exactly thresh starts vertical: visible 2+18+1 edges after drive
    cur_req = "R4"; hs_in = 1'b0; idle(18); hs_in = 1'b1; idle(2);
    chk("R4", "vs_out just before assert", vs_out, 1'b0);
    idle(1); chk("R4", "vs_out after 18-cycle pulse", vs_out, 1'b1);
    idle(10); chk("R6", "vs_out held past long trailing edge", vs_out, 1'b1);
    cur_req = "R6"; cpulse(4, 12);
    chk("R6", "vs_out cleared by short pulse", vs_out, 1'b0);
    for (int f = 0; f < 8; f++) frame(18, 1 + ($urandom % 3));

    // R7 blanking in composite mode
    hs_inhibit = 1'b1;
    for (int f = 0; f < 6; f++) begin frame(18, 3); end
    cur_req = "R7"; hs_in = 1'b0; idle(30); hs_in = 1'b1; idle(4);
    hs_in = 1'b0; idle(3);
    chk("R7", "hs_out blanked during vertical", hs_out, 1'b0);
    hs_in = 1'b1; idle(10);
    cpulse(3, 10);

    // R10 / R11 polarity codes over composite frames
    for (int p = 0; p < 4; p++) begin
      hs_pol = 2'(p); vs_pol = p[0]; hs_inhibit = p[1];
      cur_req = "R10"; frame(18, 2);
      cur_req = "R11"; frame(18, 1);
    end
    hs_pol = 2'b11; idle(3); chk("R10", "hold-high code", hs_out, 1'b1);
    hs_pol = 2'b10; idle(3); chk("R10", "hold-low code", hs_out, 1'b0);
    vs_pol = 1'b0; idle(3); chk("R11", "active-low vs idle", vs_out, 1'b1);

    // R9 disabled outputs, random config
    out_en = 1'b0; cur_req = "R9";
    for (int k = 0; k < 8; k++) begin
      hs_pol = 2'($urandom); vs_pol = 1'($urandom); comp_mode = 1'($urandom);
      frame(18, 2);
      chk("R9", "hs_out inactive", hs_out, ~hs_pol[0]);
      chk("R9", "vs_out inactive", vs_out, ~vs_pol);
    end

    // R12 zero threshold, and a small threshold
    out_en = 1'b1; hs_pol = 2'b01; vs_pol = 1'b1; comp_mode = 1'b1; hs_inhibit = 1'b0;
    thresh = 8'd0; idle(4); cur_req = "R12";
    hs_in = 1'b0; @(negedge clk); hs_in = 1'b1; idle(3);
    chk("R12", "vs_out after 1-cycle pulse, thresh 0", vs_out, 1'b1);
    idle(20);
    thresh = 8'd5; idle(10);
    for (int f = 0; f < 10; f++) frame(5, 1 + ($urandom % 3));
    thresh = 8'd18; idle(10);

    // mixed random configuration, composite and separate
    for (int k = 0; k < 20; k++) begin
      comp_mode = 1'($urandom); hs_inhibit = 1'($urandom);
      hs_pol = 2'($urandom); vs_pol = 1'($urandom); out_en = ($urandom % 4) != 0;
      cur_req = "R4";
      if (comp_mode) frame(18, 1 + ($urandom % 3)); else random_sep(200);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule